// File: doc/BRIEF.md
# Processor Effective Address Generator

This block forms the target address for one instruction of a processor with 16-bit data and 24-bit addresses. A request carries the addressing mode, up to three operand bytes, the X and Y index registers, the data bank and program bank registers, the program counter and a branch-condition flag. The program counter already points at the next opcode. The block returns a result record with these fields:

- the 24-bit address;
- the new program counter and program bank;
- for the push-relative operation, the value that is to be pushed.

Data-operand modes put the data bank on top of an index sum that wraps within 16 bits. The long indexed mode adds across all 24 bits. The relative modes move the program counter inside its current bank.

The indirect jump modes fetch a pointer from bank 0 through a byte-wide read port. That port uses a request/valid handshake. The long variant fetches a third byte, and that byte becomes the new program bank.

Requests and results both move over valid/ready handshakes. The request side takes a request only when `req_valid` and `req_ready` are both high at a clock edge. `req_ready` is low during a pointer fetch. It is also low while a result is waiting that is not taken in the same cycle.

A result is held with all fields stable until `res_ready` is high at a clock edge. A direct-mode request is taken in the same edge in which the waiting result is consumed.

Top module: `eff_addr_unit`

## Requirements
- R1: Mode 0 (index X) and mode 1 (index Y) return `res_ea` = {data bank, ({op_hi,op_lo} + index) mod 65536`}`. The program counter and program bank pass through unchanged.
- R2: Mode 2 returns `res_ea` = ({op_bank,op_hi,op_lo} + X) mod 2^24. The carry goes into the bank byte.
- R3: Mode 3 with the condition flag set returns `res_pc` = (next PC + sign-extended op_lo) mod 65536. In all relative modes (3, 4, 5) `res_pbank` equals the incoming program bank.
- R4: Mode 3 with the condition flag clear returns `res_pc` equal to the incoming next-opcode address.
- R5: Mode 4 returns `res_pc` = (next PC + signed {op_hi,op_lo}) mod 65536, with `res_ea` = {program bank, `res_pc`}.
- R6: Mode 5 sets `res_push` to 1 and `res_push_val` to the relative target, and leaves `res_pc` at the next PC. Every other mode returns `res_push` = 0.
- R7: Mode 6 reads bank-0 addresses P then (P+1) mod 65536, where P = {op_hi,op_lo}. It makes exactly two reads and returns `res_pc` = {byte at P+1, byte at P}. The program bank is unchanged.
- R8: Mode 7 also reads (P+2) mod 65536, three reads in total, and returns `res_pbank` = the byte at that address.
- R9: While `mem_req` is high, `mem_addr[23:16]` is 0, and request and address stay stable until `mem_valid`.
- R10: `ind_done` is high for exactly one cycle, in the first cycle an indirect result is presented. It never rises for modes 0 to 5.
- R11: While `res_valid` is high and `res_ready` low, the result stays valid with unchanged fields and `req_ready` is low.
- R12: After reset `res_valid`, `mem_req` and `ind_done` are 0 and `req_ready` is 1.
- R13: A request in modes 0 to 5 yields `res_valid` in the cycle after it is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken |
| req_mode | input | 3 | Addressing mode code 0..7 |
| req_op_lo | input | 8 | Operand byte 2 (low offset or pointer byte) |
| req_op_hi | input | 8 | Operand byte 3 (high offset or pointer byte) |
| req_op_bank | input | 8 | Operand byte 4 (bank of long base) |
| req_idx_x | input | 16 | X index register |
| req_idx_y | input | 16 | Y index register |
| req_dbank | input | 8 | Data bank register |
| req_pbank | input | 8 | Program bank register |
| req_pc_next | input | 16 | Program counter at next opcode |
| req_cond | input | 1 | Branch condition met |
| res_valid | output | 1 | Result present |
| res_ready | input | 1 | Result taken by consumer |
| res_ea | output | 24 | Effective or target address |
| res_pc | output | 16 | New program counter |
| res_pbank | output | 8 | New program bank |
| res_push_val | output | 16 | Value to push (mode 5) |
| res_push | output | 1 | Result is a push value |
| ind_done | output | 1 | One-cycle pulse: indirect result ready |
| mem_req | output | 1 | Pointer byte read request |
| mem_addr | output | 24 | Pointer byte address |
| mem_valid | input | 1 | Read data returned |
| mem_data | input | 8 | Read data byte |

## Verification
The bench targets sums that cross the 16-bit boundary. A design that carried into the bank would then show the wrong data bank or program bank, while one that truncated the long add would lose the bank increment.

Offsets of +127, -128, +32767 and -32768 expose a zero-extended offset as a branch that lands 256 or 65536 bytes off. A pointer at 0xFFFF or 0xFFFE shows whether the fetch wraps inside bank 0 rather than stepping into bank 1.

Slow memory replies and a held result check that nothing moves while waiting. Too many reads, a missing third byte or a lost `ind_done` pulse show up as a wrong PC, a wrong bank or a wrong pulse count.

// File: rtl/eau_pkg.sv
package eau_pkg;
  localparam int BYTE_W = 8;
  localparam int OFS_W  = 2 * BYTE_W;
  localparam int BANK_W = BYTE_W;
  localparam int ADDR_W = OFS_W + BANK_W;
  localparam int MODE_W = 3;

  typedef enum logic [MODE_W-1:0] {
    EA_ABS_X    = 3'd0,
    EA_ABS_Y    = 3'd1,
    EA_LONG_X   = 3'd2,
    EA_BR_SHORT = 3'd3,
    EA_BR_LONG  = 3'd4,
    EA_PUSH_REL = 3'd5,
    EA_IND      = 3'd6,
    EA_IND_LONG = 3'd7
  } ea_mode_e;

  typedef struct packed {
    logic [ADDR_W-1:0] ea;
    logic [OFS_W-1:0]  pc;
    logic [BANK_W-1:0] pbank;
    logic [OFS_W-1:0]  push_val;
    logic              push;
  } ea_result_t;
endpackage

// File: rtl/eau_arith.sv
module eau_arith
  import eau_pkg::*;
(
  input  logic [MODE_W-1:0] mode,
  input  logic [BYTE_W-1:0] op_lo,
  input  logic [BYTE_W-1:0] op_hi,
  input  logic [BYTE_W-1:0] op_bank,
  input  logic [OFS_W-1:0]  idx_x,
  input  logic [OFS_W-1:0]  idx_y,
  input  logic [BANK_W-1:0] dbank,
  input  logic [BANK_W-1:0] pbank,
  input  logic [OFS_W-1:0]  pc_next,
  input  logic              cond,
  output ea_result_t        res
);
  localparam int EXT_W = OFS_W - BYTE_W;

  logic [OFS_W-1:0]  base;
  logic [OFS_W-1:0]  idx;
  logic [OFS_W-1:0]  sum_ofs;
  logic [OFS_W-1:0]  short_ofs;
  logic [OFS_W-1:0]  br_short;
  logic [OFS_W-1:0]  br_long;
  logic [ADDR_W-1:0] long_sum;

  always_comb begin
    base      = {op_hi, op_lo};
    idx       = (ea_mode_e'(mode) == EA_ABS_Y) ? idx_y : idx_x;
    sum_ofs   = base + idx;
    long_sum  = {op_bank, base} + ADDR_W'(idx_x);
    short_ofs = {{EXT_W{op_lo[BYTE_W-1]}}, op_lo};
    br_short  = pc_next + short_ofs;
    br_long   = pc_next + base;

    res          = '0;
    res.pc       = pc_next;
    res.pbank    = pbank;
    res.ea       = {pbank, pc_next};
    case (ea_mode_e'(mode))
      EA_ABS_X, EA_ABS_Y: res.ea = {dbank, sum_ofs};
      EA_LONG_X:          res.ea = long_sum;
      EA_BR_SHORT: begin
        if (cond) begin
          res.pc = br_short;
          res.ea = {pbank, br_short};
        end
      end
      EA_BR_LONG: begin
        res.pc = br_long;
        res.ea = {pbank, br_long};
      end
      EA_PUSH_REL: begin
        res.push     = 1'b1;
        res.push_val = br_long;
        res.ea       = {pbank, br_long};
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/eau_ptr_fetch.sv
module eau_ptr_fetch
  import eau_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              long_in,
  input  logic [OFS_W-1:0]  ptr_in,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_valid,
  input  logic [BYTE_W-1:0] mem_data,
  output logic              busy,
  output logic              done,
  output logic [OFS_W-1:0]  pc_new,
  output logic              bank_loaded,
  output logic [BANK_W-1:0] bank_new
);
  localparam int NBYTES = 3;
  localparam int SEL_W  = $clog2(NBYTES);

  typedef enum logic [2:0] {PF_IDLE, PF_LO, PF_HI, PF_BK, PF_DONE} pf_state_e;

  pf_state_e        state_q, state_d;
  logic [OFS_W-1:0] ptr_q;
  logic             long_q;
  logic [SEL_W-1:0] sel;
  logic             beat;

  always_comb begin
    case (state_q)
      PF_HI:   sel = SEL_W'(1);
      PF_BK:   sel = SEL_W'(2);
      default: sel = '0;
    endcase
  end

  assign mem_req  = (state_q == PF_LO) || (state_q == PF_HI) || (state_q == PF_BK);
  assign mem_addr = {BANK_W'(0), ptr_q + OFS_W'(sel)};
  assign beat     = mem_req && mem_valid;
  assign busy     = (state_q != PF_IDLE);
  assign done     = (state_q == PF_DONE);

  always_comb begin
    state_d = state_q;
    case (state_q)
      PF_IDLE: if (start) state_d = PF_LO;
      PF_LO:   if (mem_valid) state_d = PF_HI;
      PF_HI:   if (mem_valid) state_d = long_q ? PF_BK : PF_DONE;
      PF_BK:   if (mem_valid) state_d = PF_DONE;
      default: state_d = PF_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PF_IDLE;
      ptr_q   <= '0;
      long_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (start && state_q == PF_IDLE) begin
        ptr_q  <= ptr_in;
        long_q <= long_in;
      end
    end
  end

  for (genvar i = 0; i < NBYTES; i++) begin : g_cap
    logic [BYTE_W-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          q <= '0;
      else if (beat && sel == SEL_W'(i))   q <= mem_data;
    end
  end

  assign pc_new      = {g_cap[1].q, g_cap[0].q};
  assign bank_new    = g_cap[2].q;
  assign bank_loaded = long_q;
endmodule

// File: rtl/eau_result_reg.sv
module eau_result_reg
  import eau_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  ea_result_t load_data,
  input  logic       load_ind,
  input  logic       take,
  output logic       valid,
  output ea_result_t data,
  output logic       ind_pulse
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid     <= 1'b0;
      data      <= '0;
      ind_pulse <= 1'b0;
    end else begin
      ind_pulse <= load && load_ind;
      if (load) begin
        valid <= 1'b1;
        data  <= load_data;
      end else if (take) begin
        valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/eff_addr_unit.sv
module eff_addr_unit
  import eau_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [MODE_W-1:0] req_mode,
  input  logic [BYTE_W-1:0] req_op_lo,
  input  logic [BYTE_W-1:0] req_op_hi,
  input  logic [BYTE_W-1:0] req_op_bank,
  input  logic [OFS_W-1:0]  req_idx_x,
  input  logic [OFS_W-1:0]  req_idx_y,
  input  logic [BANK_W-1:0] req_dbank,
  input  logic [BANK_W-1:0] req_pbank,
  input  logic [OFS_W-1:0]  req_pc_next,
  input  logic              req_cond,
  output logic              res_valid,
  input  logic              res_ready,
  output logic [ADDR_W-1:0] res_ea,
  output logic [OFS_W-1:0]  res_pc,
  output logic [BANK_W-1:0] res_pbank,
  output logic [OFS_W-1:0]  res_push_val,
  output logic              res_push,
  output logic              ind_done,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_valid,
  input  logic [BYTE_W-1:0] mem_data
);
  ea_result_t        arith_res;
  ea_result_t        ind_res;
  ea_result_t        load_res;
  ea_result_t        out_res;
  logic              accept;
  logic              is_ind;
  logic              is_ind_long;
  logic              f_busy;
  logic              f_done;
  logic              f_bank_loaded;
  logic [OFS_W-1:0]  f_pc;
  logic [BANK_W-1:0] f_bank;
  logic [BANK_W-1:0] pbank_q;
  logic              load;

  assign is_ind      = (ea_mode_e'(req_mode) == EA_IND) || (ea_mode_e'(req_mode) == EA_IND_LONG);
  assign is_ind_long = (ea_mode_e'(req_mode) == EA_IND_LONG);
  assign req_ready   = !f_busy && (!res_valid || res_ready);
  assign accept      = req_valid && req_ready;

  eau_arith u_arith (
    .mode    (req_mode),
    .op_lo   (req_op_lo),
    .op_hi   (req_op_hi),
    .op_bank (req_op_bank),
    .idx_x   (req_idx_x),
    .idx_y   (req_idx_y),
    .dbank   (req_dbank),
    .pbank   (req_pbank),
    .pc_next (req_pc_next),
    .cond    (req_cond),
    .res     (arith_res)
  );

  eau_ptr_fetch u_fetch (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (accept && is_ind),
    .long_in     (is_ind_long),
    .ptr_in      ({req_op_hi, req_op_lo}),
    .mem_req     (mem_req),
    .mem_addr    (mem_addr),
    .mem_valid   (mem_valid),
    .mem_data    (mem_data),
    .busy        (f_busy),
    .done        (f_done),
    .pc_new      (f_pc),
    .bank_loaded (f_bank_loaded),
    .bank_new    (f_bank)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 pbank_q <= '0;
    else if (accept && is_ind)  pbank_q <= req_pbank;
  end

  always_comb begin
    ind_res          = '0;
    ind_res.pc       = f_pc;
    ind_res.pbank    = f_bank_loaded ? f_bank : pbank_q;
    ind_res.ea       = {ind_res.pbank, f_pc};
  end

  assign load     = (accept && !is_ind) || f_done;
  assign load_res = f_done ? ind_res : arith_res;

  eau_result_reg u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .load_data (load_res),
    .load_ind  (f_done),
    .take      (res_ready),
    .valid     (res_valid),
    .data      (out_res),
    .ind_pulse (ind_done)
  );

  assign res_ea       = out_res.ea;
  assign res_pc       = out_res.pc;
  assign res_pbank    = out_res.pbank;
  assign res_push_val = out_res.push_val;
  assign res_push     = out_res.push;
endmodule

// File: rtl/eau_checker.sv
module eau_checker
  import eau_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [MODE_W-1:0] req_mode,
  input logic              req_cond,
  input logic [OFS_W-1:0]  req_pc_next,
  input logic [BANK_W-1:0] req_pbank,
  input logic [BANK_W-1:0] req_dbank,
  input logic              res_valid,
  input logic              res_ready,
  input logic [ADDR_W-1:0] res_ea,
  input logic [OFS_W-1:0]  res_pc,
  input logic [BANK_W-1:0] res_pbank,
  input logic [OFS_W-1:0]  res_push_val,
  input logic              res_push,
  input logic              ind_done,
  input logic              mem_req,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_valid
);
  logic acc;
  assign acc = req_valid && req_ready;

  assert_abs_bank_R1: assert property (@(posedge clk) disable iff (!rst_n)
    acc && (req_mode == 3'd0 || req_mode == 3'd1) |=> res_ea[ADDR_W-1:OFS_W] == $past(req_dbank));

  assert_rel_bank_R3: assert property (@(posedge clk) disable iff (!rst_n)
    acc && (req_mode == 3'd3 || req_mode == 3'd4 || req_mode == 3'd5) |=> res_pbank == $past(req_pbank));

  assert_not_taken_R4: assert property (@(posedge clk) disable iff (!rst_n)
    acc && req_mode == 3'd3 && !req_cond |=> res_pc == $past(req_pc_next));

  assert_push_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    acc && req_mode < 3'd6 |=> res_push == ($past(req_mode) == 3'd5));

  assert_bank_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> mem_addr[ADDR_W-1:OFS_W] == '0);

  assert_mem_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_valid |=> mem_req && $stable(mem_addr));

  assert_done_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ind_done |-> res_valid);

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ind_done |=> !ind_done);

  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_ea) && $stable(res_pc)
      && $stable(res_pbank) && $stable(res_push_val) && $stable(res_push));

  assert_no_take_R11: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |-> !req_ready);

  assert_latency_R13: assert property (@(posedge clk) disable iff (!rst_n)
    acc && req_mode < 3'd6 |=> res_valid && !ind_done);
endmodule

bind eff_addr_unit eau_checker u_eau_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .req_mode     (req_mode),
  .req_cond     (req_cond),
  .req_pc_next  (req_pc_next),
  .req_pbank    (req_pbank),
  .req_dbank    (req_dbank),
  .res_valid    (res_valid),
  .res_ready    (res_ready),
  .res_ea       (res_ea),
  .res_pc       (res_pc),
  .res_pbank    (res_pbank),
  .res_push_val (res_push_val),
  .res_push     (res_push),
  .ind_done     (ind_done),
  .mem_req      (mem_req),
  .mem_addr     (mem_addr),
  .mem_valid    (mem_valid)
);

// File: tb/eff_addr_unit_tb_top.sv
`timescale 1ns/1ps
module eff_addr_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [2:0]  req_mode = '0;
  logic [7:0]  req_op_lo = '0, req_op_hi = '0, req_op_bank = '0;
  logic [15:0] req_idx_x = '0, req_idx_y = '0;
  logic [7:0]  req_dbank = '0, req_pbank = '0;
  logic [15:0] req_pc_next = '0;
  logic        req_cond = 1'b0;
  logic        res_valid;
  logic        res_ready = 1'b1;
  logic [23:0] res_ea;
  logic [15:0] res_pc;
  logic [7:0]  res_pbank;
  logic [15:0] res_push_val;
  logic        res_push;
  logic        ind_done;
  logic        mem_req;
  logic [23:0] mem_addr;
  logic        mem_valid = 1'b0;
  logic [7:0]  mem_data = '0;

  int n_chk = 0, n_fail = 0;
  int mem_lat = 0, wcnt = 0, rd_cnt = 0, done_cnt = 0;
  logic bad_bank = 1'b0;
  logic got_first;
  logic [23:0] g_ea; logic [15:0] g_pc; logic [7:0] g_pb;
  logic [15:0] g_pv; logic g_push; logic g_done;

  always #4 clk = ~clk;

  eff_addr_unit dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_mode(req_mode), .req_op_lo(req_op_lo), .req_op_hi(req_op_hi),
    .req_op_bank(req_op_bank), .req_idx_x(req_idx_x), .req_idx_y(req_idx_y),
    .req_dbank(req_dbank), .req_pbank(req_pbank), .req_pc_next(req_pc_next),
    .req_cond(req_cond), .res_valid(res_valid), .res_ready(res_ready),
    .res_ea(res_ea), .res_pc(res_pc), .res_pbank(res_pbank),
    .res_push_val(res_push_val), .res_push(res_push), .ind_done(ind_done),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_valid(mem_valid), .mem_data(mem_data)
  );

  function automatic logic [7:0] mbyte(input logic [15:0] a);
    return 8'(a[7:0] * 8'd7 + a[15:8] + 8'h11);
  endfunction

  always @(negedge clk) begin
    if (!rst_n) begin
      mem_valid <= 1'b0;
      wcnt      <= 0;
    end else if (mem_valid) begin
      mem_valid <= 1'b0;
      wcnt      <= 0;
    end else if (mem_req) begin
      if (mem_addr[23:16] != 8'h00) bad_bank <= 1'b1;
      if (wcnt >= mem_lat) begin
        mem_valid <= 1'b1;
        mem_data  <= mbyte(mem_addr[15:0]);
        rd_cnt    <= rd_cnt + 1;
      end else begin
        wcnt <= wcnt + 1;
      end
    end
    if (rst_n && ind_done) done_cnt <= done_cnt + 1;
  end

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic issue(input logic [2:0] m, input logic [7:0] lo, input logic [7:0] hi,
                       input logic [7:0] bk, input logic [15:0] x, input logic [15:0] y,
                       input logic [7:0] db, input logic [7:0] pb, input logic [15:0] pc,
                       input logic c);
    int n;
    @(negedge clk);
    req_mode = m; req_op_lo = lo; req_op_hi = hi; req_op_bank = bk;
    req_idx_x = x; req_idx_y = y; req_dbank = db; req_pbank = pb;
    req_pc_next = pc; req_cond = c; req_valid = 1'b1;
    n = 0;
    while (!req_ready && n < 100) begin @(negedge clk); n++; end
    @(negedge clk);
    req_valid = 1'b0;
    got_first = res_valid;
    n = 0;
    while (!res_valid && n < 200) begin @(negedge clk); n++; end
    if (!res_valid) chk("timeout waiting for result", 32'd0, 32'd1);
    g_ea = res_ea; g_pc = res_pc; g_pb = res_pbank;
    g_pv = res_push_val; g_push = res_push; g_done = ind_done;
    @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R12 res_valid", 32'(res_valid), 32'd0);
    chk("R12 mem_req", 32'(mem_req), 32'd0);
    chk("R12 ind_done", 32'(ind_done), 32'd0);
    chk("R12 req_ready", 32'(req_ready), 32'd1);
  endtask

  task automatic t_abs_index;
    int d0;
    d0 = done_cnt;
    issue(3'd0, 8'h34, 8'h12, 8'h00, 16'h0102, 16'h7777, 8'h5A, 8'h21, 16'h4000, 1'b0);
    chk("R1 abs X", 32'(g_ea), 32'h5A1336);
    chk("R1 pc passthrough", 32'(g_pc), 32'h4000);
    chk("R1 pbank passthrough", 32'(g_pb), 32'h21);
    chk("R6 no push abs", 32'(g_push), 32'd0);
    chk("R13 one-cycle latency", 32'(got_first), 32'd1);
    issue(3'd0, 8'hF0, 8'hFF, 8'h00, 16'h0020, 16'h0000, 8'h12, 8'h00, 16'h0000, 1'b0);
    chk("R1 abs X wrap", 32'(g_ea), 32'h120010);
    issue(3'd1, 8'h00, 8'h80, 8'h00, 16'h1111, 16'h8001, 8'h7F, 8'h00, 16'h0000, 1'b0);
    chk("R1 abs Y wrap uses Y", 32'(g_ea), 32'h7F0001);
    chk("R10 no pulse direct", 32'(done_cnt - d0), 32'd0);
  endtask

  task automatic t_abs_long;
    issue(3'd2, 8'hF0, 8'hFF, 8'h12, 16'h0020, 16'h0000, 8'h99, 8'h00, 16'h0000, 1'b0);
    chk("R2 long carry into bank", 32'(g_ea), 32'h130010);
    issue(3'd2, 8'hFF, 8'hFF, 8'hFF, 16'h0001, 16'h0000, 8'h99, 8'h00, 16'h0000, 1'b0);
    chk("R2 long wrap 24 bits", 32'(g_ea), 32'h000000);
    issue(3'd2, 8'h00, 8'h10, 8'h03, 16'hABCD, 16'h0000, 8'h99, 8'h00, 16'h0000, 1'b0);
    chk("R2 long plain", 32'(g_ea), 32'h03BBCD);
  endtask

  task automatic t_branch_short;
    issue(3'd3, 8'h7F, 8'h00, 8'h00, 16'h0, 16'h0, 8'h00, 8'h44, 16'h1000, 1'b1);
    chk("R3 +127", 32'(g_pc), 32'h107F);
    chk("R3 pbank kept", 32'(g_pb), 32'h44);
    issue(3'd3, 8'h80, 8'h00, 8'h00, 16'h0, 16'h0, 8'h00, 8'h44, 16'h1000, 1'b1);
    chk("R3 -128", 32'(g_pc), 32'h0F80);
    issue(3'd3, 8'h7F, 8'h00, 8'h00, 16'h0, 16'h0, 8'h00, 8'h09, 16'hFFF0, 1'b1);
    chk("R3 wrap pc", 32'(g_pc), 32'h006F);
    chk("R3 wrap stays in bank", 32'(g_pb), 32'h09);
    issue(3'd3, 8'h80, 8'h00, 8'h00, 16'h0, 16'h0, 8'h00, 8'h09, 16'h2345, 1'b0);
    chk("R4 not taken", 32'(g_pc), 32'h2345);
  endtask

  task automatic t_branch_long;
    issue(3'd4, 8'hFF, 8'h7F, 8'h00, 16'h0, 16'h0, 8'h00, 8'h3C, 16'h0100, 1'b0);
    chk("R5 +32767", 32'(g_pc), 32'h80FF);
    chk("R5 ea", 32'(g_ea), 32'h3C80FF);
    issue(3'd4, 8'h00, 8'h80, 8'h00, 16'h0, 16'h0, 8'h00, 8'h3C, 16'h0100, 1'b0);
    chk("R5 -32768 wrap", 32'(g_pc), 32'h8100);
    chk("R3 long branch pbank", 32'(g_pb), 32'h3C);
  endtask

  task automatic t_push_rel;
    issue(3'd5, 8'h10, 8'h00, 8'h00, 16'h0, 16'h0, 8'h00, 8'h05, 16'hFFF8, 1'b0);
    chk("R6 push flag", 32'(g_push), 32'd1);
    chk("R6 push value wraps", 32'(g_pv), 32'h0008);
    chk("R6 pc unchanged", 32'(g_pc), 32'hFFF8);
    chk("R3 push pbank", 32'(g_pb), 32'h05);
  endtask

  task automatic t_indirect;
    int r0, d0;
    mem_lat = 0;
    r0 = rd_cnt; d0 = done_cnt;
    issue(3'd6, 8'h34, 8'h12, 8'h00, 16'h0, 16'h0, 8'h00, 8'h2A, 16'h0000, 1'b0);
    chk("R7 pc from pointer", 32'(g_pc), 32'({mbyte(16'h1235), mbyte(16'h1234)}));
    chk("R7 pbank kept", 32'(g_pb), 32'h2A);
    chk("R7 two reads", 32'(rd_cnt - r0), 32'd2);
    chk("R10 pulse with result", 32'(g_done), 32'd1);
    chk("R10 one pulse", 32'(done_cnt - d0), 32'd1);
    mem_lat = 3;
    r0 = rd_cnt;
    issue(3'd6, 8'hFF, 8'hFF, 8'h00, 16'h0, 16'h0, 8'h00, 8'h2A, 16'h0000, 1'b0);
    chk("R7 pointer wraps in bank 0", 32'(g_pc), 32'({mbyte(16'h0000), mbyte(16'hFFFF)}));
    chk("R7 two reads slow", 32'(rd_cnt - r0), 32'd2);
  endtask

  task automatic t_indirect_long;
    int r0, d0;
    mem_lat = 2;
    r0 = rd_cnt; d0 = done_cnt;
    issue(3'd7, 8'hFE, 8'hFF, 8'h00, 16'h0, 16'h0, 8'h00, 8'h2A, 16'h0000, 1'b0);
    chk("R8 pc", 32'(g_pc), 32'({mbyte(16'hFFFF), mbyte(16'hFFFE)}));
    chk("R8 pbank from third byte", 32'(g_pb), 32'(mbyte(16'h0000)));
    chk("R8 three reads", 32'(rd_cnt - r0), 32'd3);
    chk("R10 one pulse long", 32'(done_cnt - d0), 32'd1);
    chk("R9 bank 0 reads", 32'(bad_bank), 32'd0);
    mem_lat = 0;
  endtask

  task automatic t_backpressure;
    logic [23:0] ea0;
    res_ready = 1'b0;
    @(negedge clk);
    req_mode = 3'd0; req_op_lo = 8'h00; req_op_hi = 8'h20; req_idx_x = 16'h0005;
    req_dbank = 8'h11; req_valid = 1'b1;
    @(negedge clk);
    req_mode = 3'd2; req_op_lo = 8'h01; req_op_hi = 8'h00; req_op_bank = 8'h02;
    req_idx_x = 16'h0001;
    chk("R11 first result valid", 32'(res_valid), 32'd1);
    ea0 = res_ea;
    chk("R1 held result value", 32'(ea0), 32'h112005);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk("R11 still valid", 32'(res_valid), 32'd1);
      chk("R11 stable ea", 32'(res_ea), 32'(ea0));
      chk("R11 not ready", 32'(req_ready), 32'd0);
    end
    res_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R11 next result after release", 32'(res_ea), 32'h020002);
    chk("R11 next valid", 32'(res_valid), 32'd1);
    @(negedge clk);
    chk("R11 drained", 32'(res_valid), 32'd0);
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_abs_index();
    t_abs_long();
    t_branch_short();
    t_branch_long();
    t_push_rel();
    t_indirect();
    t_indirect_long();
    t_backpressure();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule